// File: doc/BRIEF.md
# Armed Sync-Triggered Capture Buffer

This block takes snapshots of a sample stream. Software arms it through a small register bus. The next sync-marked sample then opens a capture window. A programmable number of valid samples is skipped first. After that, every valid sample is written into an on-chip buffer until the buffer is full. The block then disarms itself and leaves the snapshot in place until software arms it again.

The same bus reads back several things: the captured words, the number of words stored by the current or most recent capture, the number of valid samples seen since the last sync, and the number of syncs seen since the buffer was last drained. Draining means reading the final buffer word, and that read clears the sync count. A read-only version word lets software identify the block. All bus reads return one cycle after the request, whichever region they address.

Top module: `sync_capture_buf`

## Requirements
- R1: After reset the sync count, word count, valid count and delay register all read 0, the block is unarmed, and `bus_rvalid` is low.
- R2: A read presented with `bus_rd` returns its data on `bus_rdata` with `bus_rvalid` high exactly one cycle later. The address is a byte address and only word-aligned accesses (bits 1:0 zero) take effect. With bit 12 clear the address selects registers: 0x00 sync count, 0x04 word count, 0x08 valid count, 0x0C delay, 0x1C version (default 1). Any other register address reads 0. With bit 12 set, bits 11:2 select a buffer word.
- R3: A write to register 0x08 (data ignored) arms the block. The first sync sample after arming, meaning a cycle with `st_sync` and `st_valid` both high, starts a capture. Syncs that arrive before arming store nothing.
- R4: Valid samples are numbered from 0, starting at the triggering sync sample. With delay D, sample number k ≥ D is stored at buffer word k−D. Cycles with `st_valid` low are neither counted nor stored.
- R5: A capture stops after 1024 words. The block then returns to unarmed, and later syncs do not change the buffer or the word count until it is armed again.
- R6: The word count becomes 0 at the triggering sync sample, or 1 if D is 0. It then rises by one for each stored word.
- R7: The valid count becomes 0 on every sync sample and rises by one on each later cycle with `st_valid` high.
- R8: The sync count rises by one for each sync sample. A read of buffer word 1023 clears it, and a sync sample in the same cycle as that read leaves it at 1. Register reads do not clear it.
- R9: A write to register 0x0C stores the delay, and a read of 0x0C returns the stored value.
- R10: A write to 0x08 while the block is armed or capturing has no effect. The capture in progress continues and completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_data | input | 32 | Stream sample |
| st_valid | input | 1 | Stream sample qualifier |
| st_sync | input | 1 | Marks the sample as a sync sample (with st_valid) |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 13 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after bus_rd |
| bus_rvalid | output | 1 | Read data valid |

## Verification
The hardest condition to reach from the ports is an arm write arriving in the middle of a capture that has a nonzero delay. At that moment the write must not restart or stall the capture. The stimulus arms the block with a delay of three and sends a sync followed by samples with gaps. It then pauses the stream, issues the stray arm write and reads the word count. After that it streams enough samples to overrun the buffer, so a mishandled arm shows up as a short word count or shifted buffer contents. A second capture with zero delay then confirms that the word count clears when the buffer is rewritten and that the sync sample itself lands in word 0.

// File: rtl/cap_pkg.sv
// Shared types and register word indices for the capture buffer.
// Assumes register offsets are decoded as word indices (byte offset / 4).
package cap_pkg;
    typedef enum logic [1:0] {
        CAP_IDLE  = 2'd0,
        CAP_ARMED = 2'd1,
        CAP_RUN   = 2'd2
    } cap_state_e;

    localparam logic [2:0] WI_SYNC  = 3'd0;
    localparam logic [2:0] WI_WORDS = 3'd1;
    localparam logic [2:0] WI_VALID = 3'd2;
    localparam logic [2:0] WI_DELAY = 3'd3;
    localparam logic [2:0] WI_VER   = 3'd7;
endpackage

// File: rtl/capture_ctrl.sv
// Capture sequencer: waits for arm, then for a sync sample, skips DELAY valid
// samples and issues one buffer write per valid sample until DEPTH words.
// Assumes arm_req is a single-cycle pulse and delay is stable during capture.
module capture_ctrl
    import cap_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DLY_W = 32,
    localparam int AW    = $clog2(DEPTH),
    localparam int WCW   = AW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm_req,
    input  logic [DLY_W-1:0] delay,
    input  logic             st_valid,
    input  logic             st_sync,
    output logic             wr_en,
    output logic [AW-1:0]    wr_addr,
    output logic [WCW-1:0]   word_cnt
);
    cap_state_e       state;
    logic [DLY_W-1:0] skip;
    logic             sync_smp;
    logic             dly_zero;

    assign sync_smp = st_valid && st_sync;
    assign dly_zero = (delay == '0);

    // Write strobe: sync sample itself for zero delay, otherwise once skip ran out.
    always_comb begin
        wr_en = 1'b0;
        if (state == CAP_ARMED && sync_smp && dly_zero) wr_en = 1'b1;
        if (state == CAP_RUN && st_valid && skip == '0) wr_en = 1'b1;
    end

    assign wr_addr = word_cnt[AW-1:0];

    // Sequencer state, skip countdown and stored-word count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= CAP_IDLE;
            skip     <= '0;
            word_cnt <= '0;
        end else begin
            case (state)
                CAP_IDLE: if (arm_req) state <= CAP_ARMED;
                CAP_ARMED: begin
                    if (sync_smp) begin
                        state    <= CAP_RUN;
                        word_cnt <= dly_zero ? WCW'(1) : '0;
                        skip     <= dly_zero ? '0 : delay - DLY_W'(1);
                    end
                end
                CAP_RUN: begin
                    if (st_valid) begin
                        if (skip != '0) begin
                            skip <= skip - DLY_W'(1);
                        end else begin
                            word_cnt <= word_cnt + WCW'(1);
                            if (word_cnt == WCW'(DEPTH - 1)) state <= CAP_IDLE;
                        end
                    end
                end
                default: state <= CAP_IDLE;
            endcase
        end
    end

    // R5
    words_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        word_cnt <= WCW'(DEPTH));
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_RUN && wr_en && word_cnt == WCW'(DEPTH - 1)) |=> state == CAP_IDLE);
    // R6
    wcnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_ARMED && sync_smp) |=> word_cnt <= WCW'(1));
    // R6
    wcnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_RUN && wr_en) |=> word_cnt == $past(word_cnt) + WCW'(1));
    // R10
    arm_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == CAP_RUN && arm_req && !wr_en) |=> state == CAP_RUN);
endmodule

// File: rtl/capture_counters.sv
// Stream monitors: sync count (cleared when the buffer is drained) and
// valid-sample count since the last sync sample.
// Assumes clr_sync is a single-cycle pulse from the bus decoder.
module capture_counters #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             st_valid,
    input  logic             st_sync,
    input  logic             clr_sync,
    output logic [CNT_W-1:0] sync_cnt,
    output logic [CNT_W-1:0] valid_cnt
);
    logic sync_smp;
    assign sync_smp = st_valid && st_sync;

    // Sync count: clear on drain, then add the current sync sample.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_cnt <= '0;
        else        sync_cnt <= (clr_sync ? '0 : sync_cnt) + CNT_W'(sync_smp);
    end

    // Valid count: restart at each sync sample, step on every other valid cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)        valid_cnt <= '0;
        else if (sync_smp) valid_cnt <= '0;
        else if (st_valid) valid_cnt <= valid_cnt + CNT_W'(1);
    end

    // R7
    vcnt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sync_smp |=> valid_cnt == '0);
    // R7
    vcnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !st_valid |=> $stable(valid_cnt));
    // R8
    scnt_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_sync && !sync_smp) |=> sync_cnt == '0);
endmodule

// File: rtl/capture_ram.sv
// Simple dual-port buffer: one write port from the sequencer, one registered
// read port for the bus. Assumes no reset of contents is needed.
module capture_ram #(
    parameter int W     = 32,
    parameter int DEPTH = 1024,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] mem [DEPTH];

    // Store a captured sample.
    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    // Registered read for the bus.
    always_ff @(posedge clk) begin
        if (rd_en) rd_data <= mem[rd_addr];
    end
endmodule

// File: rtl/sync_capture_buf.sv
// Top level: bus decode, delay register, read mux with one-cycle latency,
// and the sequencer, counters and buffer. Assumes a single clock domain and
// word-aligned byte addresses; bit AW+2 selects the buffer region.
module sync_capture_buf
    import cap_pkg::*;
#(
    parameter int          DATA_W  = 32,
    parameter int          DEPTH   = 1024,
    parameter int          DLY_W   = 32,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'd1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          st_data,
    input  logic                       st_valid,
    input  logic                       st_sync,
    input  logic                       bus_wr,
    input  logic                       bus_rd,
    input  logic [$clog2(DEPTH)+2:0]   bus_addr,
    input  logic [DATA_W-1:0]          bus_wdata,
    output logic [DATA_W-1:0]          bus_rdata,
    output logic                       bus_rvalid
);
    localparam int AW  = $clog2(DEPTH);
    localparam int WCW = AW + 1;

    logic             aligned, is_buf, reg_hit, buf_rd, arm_req, clr_sync;
    logic [2:0]       widx;
    logic [AW-1:0]    buf_idx;
    logic [DLY_W-1:0] delay_q;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;
    logic [WCW-1:0]   word_cnt;
    logic [CNT_W-1:0] sync_cnt, valid_cnt;
    logic [DATA_W-1:0] reg_mux, reg_q, ram_q;
    logic             rsel_buf;

    assign aligned  = (bus_addr[1:0] == 2'b00);
    assign is_buf   = bus_addr[AW+2];
    assign buf_idx  = bus_addr[AW+1:2];
    assign widx     = bus_addr[4:2];
    assign reg_hit  = aligned && !is_buf && (bus_addr[AW+1:5] == '0);
    assign buf_rd   = bus_rd && aligned && is_buf;
    assign arm_req  = bus_wr && reg_hit && widx == WI_VALID;
    assign clr_sync = buf_rd && buf_idx == AW'(DEPTH - 1);

    // Delay register write.
    always_ff @(posedge clk) begin
        if (!rst_n)                                delay_q <= '0;
        else if (bus_wr && reg_hit && widx == WI_DELAY) delay_q <= bus_wdata[DLY_W-1:0];
    end

    // Register read selection.
    always_comb begin
        reg_mux = '0;
        if (reg_hit) begin
            case (widx)
                WI_SYNC:  reg_mux = DATA_W'(sync_cnt);
                WI_WORDS: reg_mux = DATA_W'(word_cnt);
                WI_VALID: reg_mux = DATA_W'(valid_cnt);
                WI_DELAY: reg_mux = DATA_W'(delay_q);
                WI_VER:   reg_mux = DATA_W'(VERSION);
                default:  reg_mux = '0;
            endcase
        end
    end

    // Read response pipeline: one cycle for registers and buffer alike.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bus_rvalid <= 1'b0;
            rsel_buf   <= 1'b0;
            reg_q      <= '0;
        end else begin
            bus_rvalid <= bus_rd;
            rsel_buf   <= buf_rd;
            if (bus_rd) reg_q <= reg_mux;
        end
    end

    assign bus_rdata = rsel_buf ? ram_q : reg_q;

    capture_ctrl #(.DEPTH(DEPTH), .DLY_W(DLY_W)) i_ctrl (
        .clk(clk), .rst_n(rst_n), .arm_req(arm_req), .delay(delay_q),
        .st_valid(st_valid), .st_sync(st_sync),
        .wr_en(wr_en), .wr_addr(wr_addr), .word_cnt(word_cnt)
    );

    capture_counters #(.CNT_W(CNT_W)) i_cnt (
        .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_sync(st_sync),
        .clr_sync(clr_sync), .sync_cnt(sync_cnt), .valid_cnt(valid_cnt)
    );

    capture_ram #(.W(DATA_W), .DEPTH(DEPTH)) i_ram (
        .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(st_data),
        .rd_en(buf_rd), .rd_addr(buf_idx), .rd_data(ram_q)
    );

    // R2
    rvalid_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid);
    // R2
    rvalid_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid);
    // R9
    delay_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(delay_q));
endmodule

// File: tb/test_sync_capture_buf.sv
`timescale 1ns/1ps
module test_sync_capture_buf;
    localparam logic [31:0] BASE = 32'hC0DE_0000;
    localparam logic [12:0] BUF  = 13'h1000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] st_data = '0;
    logic        st_valid = 1'b0, st_sync = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [12:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;

    int checks = 0, failures = 0, serial = 0, cycles = 0;
    int s0, s1;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #2.5 clk = ~clk;

    sync_capture_buf i_sync_capture_buf (
        .clk(clk), .rst_n(rst_n), .st_data(st_data), .st_valid(st_valid),
        .st_sync(st_sync), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid)
    );

    // Monitor: pop one expected item per returned read and compare.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            checks++;
            if (exp_q.size() == 0) begin
                failures++;
                $display("FAIL R2 unexpected rvalid: actual %h expected none", bus_rdata);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (bus_rdata !== e) begin
                    failures++;
                    $display("FAIL %s: actual %h expected %h", t, bus_rdata, e);
                end
            end
        end
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            failures++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    task automatic rd(input logic [12:0] a, input logic [31:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(negedge clk); bus_rd = 1'b1; bus_addr = a;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic stream(input int n, input bit with_sync, input int gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            st_valid = 1'b1;
            st_sync  = with_sync && (i == 0);
            st_data  = BASE + 32'(serial);
            serial++;
            if (gap > 0 && (i % gap) == gap - 1) begin
                @(negedge clk); st_valid = 1'b0; st_sync = 1'b0;
            end
        end
        @(negedge clk); st_valid = 1'b0; st_sync = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state, R2 map
        rd(13'h000, 32'd0, "R1 sync count");
        rd(13'h004, 32'd0, "R1 word count");
        rd(13'h008, 32'd0, "R1 valid count");
        rd(13'h00C, 32'd0, "R1 delay");
        rd(13'h01C, 32'd1, "R2 version");
        rd(13'h010, 32'd0, "R2 unmapped");
        // R3 sync before arming stores nothing; R7 and R8 counts
        stream(4, 1'b1, 0);
        rd(13'h000, 32'd1, "R8 sync count");
        rd(13'h008, 32'd3, "R7 valid count");
        rd(13'h004, 32'd0, "R3 unarmed no words");
        // R9 delay register
        wr(13'h00C, 32'h0001_2345);
        rd(13'h00C, 32'h0001_2345, "R9 delay readback");
        wr(13'h00C, 32'd3);
        rd(13'h00C, 32'd3, "R9 delay 3");
        // Capture with delay 3
        wr(13'h008, 32'd0);
        stream(2, 1'b0, 0);
        s0 = serial;
        stream(10, 1'b1, 3);
        wr(13'h008, 32'd0);                          // R10 stray arm
        rd(13'h004, 32'd7, "R6 words mid capture");
        rd(13'h008, 32'd9, "R7 valid since sync");
        stream(1022, 1'b0, 5);
        rd(13'h004, 32'd1024, "R10 capture completed");
        rd(13'h008, 32'd1031, "R7 valid long");
        // R5 later sync leaves buffer alone
        stream(5, 1'b1, 0);
        rd(13'h008, 32'd4, "R7 valid after new sync");
        rd(13'h004, 32'd1024, "R5 word count kept");
        rd(BUF | 13'(0 << 2), BASE + 32'(s0 + 3), "R4 word 0 delay 3");
        rd(BUF | 13'(1 << 2), BASE + 32'(s0 + 4), "R4 word 1");
        rd(BUF | 13'(500 << 2), BASE + 32'(s0 + 503), "R4 word 500 gaps");
        rd(13'h000, 32'd3, "R8 sync count not cleared by reg read");
        rd(BUF | 13'(1023 << 2), BASE + 32'(s0 + 1026), "R5 last word");
        rd(13'h000, 32'd0, "R8 cleared by last word read");
        // Capture with delay 0
        wr(13'h00C, 32'd0);
        wr(13'h008, 32'd0);
        s1 = serial;
        stream(5, 1'b1, 2);
        rd(13'h004, 32'd5, "R6 word count cleared on rewrite");
        stream(1019, 1'b0, 0);
        rd(13'h004, 32'd1024, "R5 second capture full");
        rd(BUF, BASE + 32'(s1), "R4 sync sample at word 0");
        rd(BUF | 13'(1023 << 2), BASE + 32'(s1 + 1023), "R4 last word delay 0");
        repeat (3) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            failures++;
            $display("FAIL R2 missing responses: actual %0d pending expected 0", exp_q.size());
        end
        finish_run();
    end
endmodule